// File: doc/BRIEF.md
# Dual-Port Semaphore and Interrupt Tester

This block is a test controller that sits in front of a dual-ported RAM which has hardware semaphore latches and one interrupt mailbox per port. After a `start` pulse it drives both RAM ports at once. For every semaphore and for each port taking the owner role in turn, it runs a fixed sequence. The owner requests the latch, and both ports read it back to confirm ownership. The other port then tries to take the latch and must be refused. The owner releases it, the other port takes it, and finally that port releases it.

A second phase checks the mailboxes. Both ports write the other port's mailbox in the same cycle, and the tester waits for both interrupt lines to rise. Each port then reads its own mailbox, which must return the sender's pattern and must clear that port's interrupt.

The first failure stops the run. It is reported as a code that holds the failure kind, the port and the semaphore or mailbox number. Every access waits for the RAM's per-port acknowledge, and a watchdog turns a missing acknowledge or interrupt into a reported failure instead of a hang.

Top module: `dpsem_tester`

## Requirements
- R1: After reset `done`, `pass`, `fail_code` and both chip selects are 0. A `start` pulse, given while idle or after a finished run, begins a new run. `done` stays high when the run ends, and once `done` has been high for a cycle no chip select is active.
- R2: A semaphore access drives `port_sem`=1 with the semaphore index in the low address bits. A write with data bit 0 = 1 requests the latch and a write with bit 0 = 0 releases it. A read returns bit 0 = 1 exactly when the reading port holds the latch.
- R3: If a port that requested a latch, and should hold it, reads bit 0 = 0, the run fails with kind 1 (not set).
- R4: If a port reads bit 0 = 1 after it released the latch, the run fails with kind 2 (not released).
- R5: If a port reads a latch as held while the other port owns it, or after the other port has released it, the run fails with kind 6 (granted to both).
- R6: Port 0's mailbox is at the all-ones address and port 1's mailbox one below it. Both ports write the other port's mailbox in the same cycle, port 0 with PAT0 and port 1 with PAT1. If both interrupts are not high within TIMEOUT cycles, the run fails with kind 3. The reported port and index are the first port (port 0 before port 1) whose interrupt is missing.
- R7: Each port then reads its own mailbox. The data must equal the other port's pattern, or the run fails with kind 7. One cycle after both reads complete, both interrupts must be low, or the run fails with kind 4 (port 0 checked first).
- R8: Each access holds its chip select until that port's acknowledge. If an acknowledge is still missing after TIMEOUT cycles of waiting, the run fails with kind 5 for the first port still waiting.
- R9: `fail_code` = {kind[2:0], port, index[SIW-1:0]}. When two ports fail in the same step, port 0 is reported. The code is 0 when `pass` is 1, and it stays unchanged while `done` is high.
- R10: In steps where both ports have an access, both chip selects rise in the same cycle, and each access is issued exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a test run |
| port_cs | output | 2 | Chip select, one bit per port |
| port_we | output | 2 | Write enable per port |
| port_sem | output | 2 | Semaphore space select per port |
| port_addr | output | 2×AW | Address per port |
| port_wdata | output | 2×DW | Write data per port |
| port_rdata | input | 2×DW | Read data per port, valid with acknowledge |
| port_ack | input | 2 | One-cycle access acknowledge per port |
| port_int | input | 2 | Interrupt output of each RAM port |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished with no failure |
| fail_code | output | 4+SIW | First failure: kind, port, index |

## Verification
Two functions of this block meet in the same cycle. In step six of every semaphore sequence, one port reads the latch it has just released while the other port writes its request. In the mailbox phase, both ports write and both interrupts are raised on the same edge. The bench's RAM model applies both ports' operations on one edge, using the pre-edge latch state for the grant decision. The bench counts the cycles in which both chip selects are high. A clean run must pass with a nonzero count. Injected faults in the latch grant, the release, an interrupt raise or an interrupt clear must each give the exact fail code that the step order predicts.

// File: rtl/dpsem_pkg.sv
package dpsem_pkg;

    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_WR  = 2'd1,
        OP_RD  = 2'd2
    } op_e;

    typedef enum logic [2:0] {
        FK_NONE    = 3'd0,
        FK_NOSET   = 3'd1,
        FK_NOREL   = 3'd2,
        FK_NOINT   = 3'd3,
        FK_NOCLEAR = 3'd4,
        FK_TIMEOUT = 3'd5,
        FK_DOUBLE  = 3'd6,
        FK_BADDATA = 3'd7
    } fkind_e;

    // one port's action inside a semaphore step
    typedef struct packed {
        op_e    op;
        logic   wbit;   // bit 0 written: 1 request, 0 release
        logic   ebit;   // expected read bit 0
        fkind_e kind;   // reported when the read mismatches
    } sem_op_t;

    typedef struct packed {
        sem_op_t own;   // port taking the owner role
        sem_op_t oth;   // the opposite port
    } sem_step_t;

    localparam int SEM_STEPS = 9;

    function automatic sem_op_t mk(op_e op, logic w, logic e, fkind_e k);
        sem_op_t r;
        r.op = op; r.wbit = w; r.ebit = e; r.kind = k;
        return r;
    endfunction

    function automatic sem_step_t sem_step(input int unsigned s);
        sem_step_t r;
        sem_op_t   idle;
        idle = mk(OP_NOP, 1'b0, 1'b0, FK_NONE);
        r.own = idle;
        r.oth = idle;
        case (s)
            0: r.own = mk(OP_WR, 1'b1, 1'b0, FK_NONE);
            1: begin r.own = mk(OP_RD, 1'b0, 1'b1, FK_NOSET);
                     r.oth = mk(OP_RD, 1'b0, 1'b0, FK_DOUBLE); end
            2: r.oth = mk(OP_WR, 1'b1, 1'b0, FK_NONE);
            3: begin r.own = mk(OP_RD, 1'b0, 1'b1, FK_NOSET);
                     r.oth = mk(OP_RD, 1'b0, 1'b0, FK_DOUBLE); end
            4: r.own = mk(OP_WR, 1'b0, 1'b0, FK_NONE);
            5: begin r.own = mk(OP_RD, 1'b0, 1'b0, FK_NOREL);
                     r.oth = mk(OP_WR, 1'b1, 1'b0, FK_NONE); end
            6: begin r.own = mk(OP_RD, 1'b0, 1'b0, FK_DOUBLE);
                     r.oth = mk(OP_RD, 1'b0, 1'b1, FK_NOSET); end
            7: r.oth = mk(OP_WR, 1'b0, 1'b0, FK_NONE);
            8: begin r.own = mk(OP_RD, 1'b0, 1'b0, FK_DOUBLE);
                     r.oth = mk(OP_RD, 1'b0, 1'b0, FK_NOREL); end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dpsem_wdog.sv
module dpsem_wdog #(
    parameter int LIMIT = 32,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en)            cnt <= '0;
        else if (cnt != CW'(LIMIT)) cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == CW'(LIMIT));

    // R8
    wdog_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (!en) |=> (!expired || $past(LIMIT == 0)));
endmodule

// File: rtl/dpsem_port_drv.sv
module dpsem_port_drv import dpsem_pkg::*; #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          abort,
    input  logic [1:0]    req_op,
    input  logic          req_sem,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          got,
    output logic [DW-1:0] cap,
    output logic          cs,
    output logic          we,
    output logic          sem,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    input  logic          ack,
    input  logic [DW-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cs <= 1'b0; we <= 1'b0; sem <= 1'b0;
            addr <= '0; wdata <= '0; got <= 1'b0; cap <= '0;
        end else begin
            got <= 1'b0;
            if (abort) begin
                cs <= 1'b0;
            end else if (go && op_e'(req_op) != OP_NOP) begin
                cs    <= 1'b1;
                we    <= (op_e'(req_op) == OP_WR);
                sem   <= req_sem;
                addr  <= req_addr;
                wdata <= req_wdata;
            end else if (cs && ack) begin
                cs  <= 1'b0;
                got <= 1'b1;
                cap <= rdata;
            end
        end
    end

    // R10
    cs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cs && !ack && !abort) |=> (cs && $stable(addr) && $stable(we)));
endmodule

// File: rtl/dpsem_seq.sv
module dpsem_seq import dpsem_pkg::*; #(
    parameter int AW = 6,
    parameter int DW = 8,
    parameter int NSEM = 4,
    parameter logic [DW-1:0] PAT0 = 8'hA5,
    parameter logic [DW-1:0] PAT1 = 8'h3C,
    localparam int SIW = (NSEM > 1) ? $clog2(NSEM) : 1,
    localparam int FCW = 4 + SIW
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [1:0]          got,
    input  logic [1:0][DW-1:0]  cap,
    input  logic [1:0]          intr,
    input  logic                wd_exp,
    output logic                go,
    output logic                abort,
    output logic                waiting,
    output logic [1:0][1:0]     p_op,
    output logic [1:0]          p_sem,
    output logic [1:0][AW-1:0]  p_addr,
    output logic [1:0][DW-1:0]  p_wdata,
    output logic                done,
    output logic                pass,
    output logic [FCW-1:0]      fail_code
);
    localparam int SW = $clog2(SEM_STEPS);
    localparam logic [AW-1:0] MB0 = '1;
    localparam logic [AW-1:0] MB1 = MB0 - 1'b1;

    typedef enum logic [2:0] {
        S_IDLE, S_ISSUE, S_WAIT, S_CHECK, S_MBINT, S_MBCLR, S_DONE
    } st_e;

    st_e            state;
    logic [SW-1:0]  step;
    logic           owner, mb, mstep;
    logic [SIW-1:0] sem_idx;
    logic [1:0]     pend;
    fkind_e         fkind;
    logic           fport;
    logic [SIW-1:0] fidx;

    logic [1:0][DW-1:0] p_mask, p_exp;
    fkind_e [1:0]       p_kind;
    sem_step_t          st;
    sem_op_t            d;
    logic               chk_fail, chk_port;
    fkind_e             chk_kind;

    always_comb begin
        st = sem_step(32'(step));
        d  = st.own;
        for (int p = 0; p < 2; p++) begin
            d = (p == int'(owner)) ? st.own : st.oth;
            if (!mb) begin
                p_op[p]    = d.op;
                p_sem[p]   = 1'b1;
                p_addr[p]  = AW'(sem_idx);
                p_wdata[p] = DW'(d.wbit);
                p_mask[p]  = DW'(1);
                p_exp[p]   = DW'(d.ebit);
                p_kind[p]  = d.kind;
            end else begin
                p_op[p]    = mstep ? OP_RD : OP_WR;
                p_sem[p]   = 1'b0;
                p_addr[p]  = mstep ? ((p == 0) ? MB0 : MB1) : ((p == 0) ? MB1 : MB0);
                p_wdata[p] = (p == 0) ? PAT0 : PAT1;
                p_mask[p]  = '1;
                p_exp[p]   = (p == 0) ? PAT1 : PAT0;
                p_kind[p]  = FK_BADDATA;
            end
        end
        chk_fail = 1'b0;
        chk_port = 1'b0;
        chk_kind = FK_NONE;
        for (int p = 1; p >= 0; p--) begin
            if (op_e'(p_op[p]) == OP_RD && ((cap[p] & p_mask[p]) != p_exp[p])) begin
                chk_fail = 1'b1;
                chk_port = 1'(p);
                chk_kind = p_kind[p];
            end
        end
    end

    assign go        = (state == S_ISSUE);
    assign abort     = (state == S_DONE);
    assign waiting   = (state == S_WAIT) || (state == S_MBINT);
    assign done      = (state == S_DONE);
    assign fail_code = {fkind, fport, fidx};

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE; step <= '0; owner <= 1'b0; mb <= 1'b0; mstep <= 1'b0;
            sem_idx <= '0; pend <= '0; pass <= 1'b0;
            fkind <= FK_NONE; fport <= 1'b0; fidx <= '0;
        end else begin
            case (state)
                S_IDLE, S_DONE: if (start) begin
                    state <= S_ISSUE; step <= '0; owner <= 1'b0; mb <= 1'b0;
                    mstep <= 1'b0; sem_idx <= '0; pass <= 1'b0;
                    fkind <= FK_NONE; fport <= 1'b0; fidx <= '0;
                end
                S_ISSUE: begin
                    for (int p = 0; p < 2; p++) pend[p] <= (op_e'(p_op[p]) != OP_NOP);
                    state <= S_WAIT;
                end
                S_WAIT: begin
                    if (wd_exp) begin
                        fkind <= FK_TIMEOUT;
                        fport <= !pend[0];
                        fidx  <= mb ? SIW'(!pend[0]) : sem_idx;
                        state <= S_DONE;
                    end else begin
                        pend <= pend & ~got;
                        if ((pend & ~got) == 2'b00) state <= S_CHECK;
                    end
                end
                S_CHECK: begin
                    if (chk_fail) begin
                        fkind <= chk_kind;
                        fport <= chk_port;
                        fidx  <= mb ? SIW'(chk_port) : sem_idx;
                        state <= S_DONE;
                    end else if (!mb) begin
                        state <= S_ISSUE;
                        if (step == SW'(SEM_STEPS - 1)) begin
                            step  <= '0;
                            owner <= !owner;
                            if (owner) begin
                                if (sem_idx == SIW'(NSEM - 1)) mb <= 1'b1;
                                else sem_idx <= sem_idx + 1'b1;
                            end
                        end else begin
                            step <= step + 1'b1;
                        end
                    end else begin
                        state <= mstep ? S_MBCLR : S_MBINT;
                    end
                end
                S_MBINT: begin
                    if (intr == 2'b11) begin
                        mstep <= 1'b1;
                        state <= S_ISSUE;
                    end else if (wd_exp) begin
                        fkind <= FK_NOINT;
                        fport <= intr[0];
                        fidx  <= SIW'(intr[0]);
                        state <= S_DONE;
                    end
                end
                S_MBCLR: begin
                    if (intr[0]) begin
                        fkind <= FK_NOCLEAR; fport <= 1'b0; fidx <= '0;
                    end else if (intr[1]) begin
                        fkind <= FK_NOCLEAR; fport <= 1'b1; fidx <= SIW'(1);
                    end else begin
                        pass <= 1'b1;
                    end
                    state <= S_DONE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R9
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && $past(done) && !$past(start)) |-> $stable(fail_code));
    // R9
    pass_code_chk: assert property (@(posedge clk) disable iff (rst)
        pass |-> (fail_code == '0));
    // R7
    clr_fail_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_MBCLR && intr[0]) |=> (done && !pass));
endmodule

// File: rtl/dpsem_tester.sv
module dpsem_tester import dpsem_pkg::*; #(
    parameter int AW = 6,
    parameter int DW = 8,
    parameter int NSEM = 4,
    parameter int TIMEOUT = 32,
    parameter logic [DW-1:0] PAT0 = 8'hA5,
    parameter logic [DW-1:0] PAT1 = 8'h3C,
    localparam int SIW = (NSEM > 1) ? $clog2(NSEM) : 1,
    localparam int FCW = 4 + SIW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    output logic [1:0]         port_cs,
    output logic [1:0]         port_we,
    output logic [1:0]         port_sem,
    output logic [1:0][AW-1:0] port_addr,
    output logic [1:0][DW-1:0] port_wdata,
    input  logic [1:0][DW-1:0] port_rdata,
    input  logic [1:0]         port_ack,
    input  logic [1:0]         port_int,
    output logic               done,
    output logic               pass,
    output logic [FCW-1:0]     fail_code
);
    logic               go, abort, waiting, wd_exp;
    logic [1:0]         got;
    logic [1:0][DW-1:0] cap;
    logic [1:0][1:0]    p_op;
    logic [1:0]         p_sem;
    logic [1:0][AW-1:0] p_addr;
    logic [1:0][DW-1:0] p_wdata;

    dpsem_seq #(.AW(AW), .DW(DW), .NSEM(NSEM), .PAT0(PAT0), .PAT1(PAT1)) u_seq (
        .clk(clk), .rst(rst), .start(start), .got(got), .cap(cap),
        .intr(port_int), .wd_exp(wd_exp), .go(go), .abort(abort),
        .waiting(waiting), .p_op(p_op), .p_sem(p_sem), .p_addr(p_addr),
        .p_wdata(p_wdata), .done(done), .pass(pass), .fail_code(fail_code)
    );

    dpsem_wdog #(.LIMIT(TIMEOUT)) u_wdog (
        .clk(clk), .rst(rst), .en(waiting), .expired(wd_exp)
    );

    for (genvar p = 0; p < 2; p++) begin : g_port
        dpsem_port_drv #(.AW(AW), .DW(DW)) u_drv (
            .clk(clk), .rst(rst), .go(go), .abort(abort),
            .req_op(p_op[p]), .req_sem(p_sem[p]), .req_addr(p_addr[p]),
            .req_wdata(p_wdata[p]), .got(got[p]), .cap(cap[p]),
            .cs(port_cs[p]), .we(port_we[p]), .sem(port_sem[p]),
            .addr(port_addr[p]), .wdata(port_wdata[p]),
            .ack(port_ack[p]), .rdata(port_rdata[p])
        );
    end

    // R1
    idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (done && $past(done)) |-> (port_cs == 2'b00));
endmodule

// File: tb/dpsem_tester_bench.sv
`timescale 1ns/1ps
module dpsem_tester_bench;
    localparam int AW = 6, DW = 8, NSEM = 4, TMO = 32;
    localparam logic [AW-1:0] MB0 = '1;
    localparam logic [AW-1:0] MB1 = MB0 - 1'b1;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [1:0] cs, we, sem, ack, irq;
    logic [1:0][AW-1:0] addr;
    logic [1:0][DW-1:0] wdata, rd, mb;
    logic [1:0][NSEM-1:0] own;
    logic done, pass;
    logic [5:0] code;
    logic f_noset = 0, f_norel = 0, f_double = 0, f_noint1 = 0, f_noclr0 = 0, f_hang = 0;
    int total = 0, bad = 0, both_cnt = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dpsem_tester #(.AW(AW), .DW(DW), .NSEM(NSEM), .TIMEOUT(TMO)) u_dpsem_tester (
        .clk(clk), .rst(rst), .start(start), .port_cs(cs), .port_we(we),
        .port_sem(sem), .port_addr(addr), .port_wdata(wdata), .port_rdata(rd),
        .port_ack(ack), .port_int(irq), .done(done), .pass(pass), .fail_code(code)
    );

    // RAM model: one-cycle acknowledge, semaphore latches, two mailboxes
    always @(posedge clk) begin
        if (rst) begin
            ack <= '0; own <= '0; irq <= '0; mb <= '0; rd <= '0;
        end else begin
            if (&cs) both_cnt <= both_cnt + 1;
            for (int p = 0; p < 2; p++) begin
                ack[p] <= 1'b0;
                if (cs[p] && !ack[p] && !(f_hang && p == 1)) begin
                    ack[p] <= 1'b1;
                    if (sem[p]) begin
                        if (we[p]) begin
                            if (wdata[p][0]) begin
                                if ((!own[1-p][addr[p][1:0]] || f_double) &&
                                    !(f_noset && addr[p][1:0] == 2'd2))
                                    own[p][addr[p][1:0]] <= 1'b1;
                            end else if (!(f_norel && addr[p][1:0] == 2'd1)) begin
                                own[p][addr[p][1:0]] <= 1'b0;
                            end
                        end else begin
                            rd[p] <= {7'd0, own[p][addr[p][1:0]]};
                        end
                    end else if (we[p]) begin
                        if (addr[p] == MB0) begin mb[0] <= wdata[p]; irq[0] <= 1'b1; end
                        if (addr[p] == MB1) begin mb[1] <= wdata[p]; if (!f_noint1) irq[1] <= 1'b1; end
                    end else begin
                        if (addr[p] == MB0) begin rd[p] <= mb[0]; if (p == 0 && !f_noclr0) irq[0] <= 1'b0; end
                        if (addr[p] == MB1) begin rd[p] <= mb[1]; if (p == 1) irq[1] <= 1'b0; end
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        both_cnt = 0;
    endtask

    task automatic run_and_wait();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic test_reset();
        do_reset();
        chk(done == 0 && pass == 0, "R1 reset flags", {done, pass}, 0);
        chk(code == 0, "R1 reset code", code, 0);
        chk(cs == 0, "R1 reset cs", cs, 0);
    endtask

    task automatic test_clean();
        do_reset();
        run_and_wait();
        chk(done == 1, "R1 done", done, 1);
        chk(pass == 1, "R2 R7 clean pass", pass, 1);
        chk(code == 0, "R9 clean code", code, 0);
        chk(both_cnt > 0, "R10 simultaneous access", both_cnt, 1);
        chk(cs == 0, "R1 idle bus", cs, 0);
        run_and_wait();
        chk(pass == 1 && done == 1, "R1 restart", {done, pass}, 3);
    endtask

    task automatic test_fault(input string req, input logic [5:0] exp);
        do_reset();
        run_and_wait();
        chk(done == 1 && pass == 0 && code == exp, req, code, exp);
        f_noset = 0; f_norel = 0; f_double = 0; f_noint1 = 0; f_noclr0 = 0; f_hang = 0;
    endtask

    initial begin
        test_reset();
        test_clean();
        f_noset = 1;  test_fault("R3 no set",   {3'd1, 1'b0, 2'd2});
        f_norel = 1;  test_fault("R4 no release", {3'd2, 1'b0, 2'd1});
        f_double = 1; test_fault("R5 double grant", {3'd6, 1'b1, 2'd0});
        f_noint1 = 1; test_fault("R6 no interrupt", {3'd3, 1'b1, 2'd1});
        f_noclr0 = 1; test_fault("R7 no clear", {3'd4, 1'b0, 2'd0});
        f_hang = 1;   test_fault("R8 R9 timeout", {3'd5, 1'b1, 2'd0});
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule